// File: doc/BRIEF.md
# Allocation Look-aside Buffer

This block is a small, fully associative store that sits in front of a bit-map heap allocator. Each slot caches one heap page: its page number, an owner process id, the page's allocation, size and mark bit-vectors, and a capacity field that gives the largest free run on that page. An allocation request compares the requested size against every slot's capacity at the same time. The lowest-index slot that can hold the request is selected, and its vectors are presented to the allocator. A mark request splits an object pointer into page and offset. The page is matched against the slot tags, and on a hit the bit at the offset is set in that slot's mark vector.

A lookup that finds nothing raises a one-cycle miss flag. An external controller then writes a page image through the fill port. Fills go to the lowest empty slot first. Once every slot is occupied, fills replace slots in the order they were loaded. After an allocation hit, the allocator returns the updated vectors, the new capacity and the chosen offset on the update port. The block writes these back into the selected slot and returns the object pointer, formed as page number followed by offset.

Top module: `alloc_lookaside_buf`

## Requirements
- R1: After reset every slot is empty, all hit, miss and pointer-valid flags are low, and the fill victim index is 0.
- R2: One cycle after an allocation request, `alloc_hit_o` is high if and only if some occupied slot with a matching process id has a capacity greater than or equal to the request size. Equality counts as a fit.
- R3: When several slots fit, `hit_idx_o` names the lowest-index one. `sel_a_o`, `sel_s_o`, `sel_x_o` and `sel_cap_o` then show that slot's contents.
- R4: One cycle after an allocation request that fits no slot, `alloc_miss_o` is high. Empty slots never fit.
- R5: A mark pointer is {page, offset}, with the offset in the low log2(BV_LEN) bits. One cycle after a mark request whose page and process id match an occupied slot, `mark_hit_o` is high and `hit_idx_o` names that slot. `mark_off_o` carries the offset, and the bit at that offset in the slot's mark vector is set, as seen on `sel_x_o`.
- R6: A mark request that matches no slot raises `mark_miss_o` and changes no slot. `hit_idx_o` keeps its previous value.
- R7: When `USE_PID` is 1, a slot owned by another process id never hits an allocation or a mark lookup.
- R8: An update in the cycle after an allocation hit writes the allocation vector, size vector and capacity into the selected slot. One cycle later `ptr_vld_o` is high with `obj_ptr_o` = {slot page, `upd_off_i`}, two edges after the request.
- R9: While any slot is empty, `victim_idx_o` is the lowest-index empty slot, and a fill writes that slot.
- R10: When all slots are occupied, `victim_idx_o` follows a pointer that starts at 0 and advances by one, wrapping modulo N_ENT, on each fill that evicts.
- R11: Hit, miss and pointer-valid flags are single-cycle pulses. Hit and miss are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pid_i | input | PID_W | Process id of the current request |
| alloc_req_i | input | 1 | Allocation lookup request |
| alloc_size_i | input | log2(BV_LEN)+1 | Requested size in blocks |
| mark_req_i | input | 1 | Mark request |
| mark_ptr_i | input | PAGE_W+log2(BV_LEN) | Object pointer {page, offset} |
| alloc_hit_o | output | 1 | Allocation lookup hit |
| alloc_miss_o | output | 1 | Allocation lookup miss |
| mark_hit_o | output | 1 | Mark lookup hit |
| mark_miss_o | output | 1 | Mark lookup miss |
| hit_idx_o | output | log2(N_ENT) | Selected slot |
| mark_off_o | output | log2(BV_LEN) | Forwarded bit address of the last mark |
| sel_a_o | output | BV_LEN | Allocation vector of the selected slot |
| sel_s_o | output | BV_LEN | Size vector of the selected slot |
| sel_x_o | output | BV_LEN | Mark vector of the selected slot |
| sel_cap_o | output | log2(BV_LEN)+1 | Capacity of the selected slot |
| upd_en_i | input | 1 | Write back allocator result |
| upd_a_i | input | BV_LEN | New allocation vector |
| upd_s_i | input | BV_LEN | New size vector |
| upd_cap_i | input | log2(BV_LEN)+1 | New capacity |
| upd_off_i | input | log2(BV_LEN) | Offset of the new object |
| ptr_vld_o | output | 1 | Object pointer valid |
| obj_ptr_o | output | PAGE_W+log2(BV_LEN) | Object pointer {page, offset} |
| fill_en_i | input | 1 | Load a slot |
| fill_pid_i | input | PID_W | Process id for the loaded slot |
| fill_page_i | input | PAGE_W | Page number for the loaded slot |
| fill_a_i | input | BV_LEN | Allocation vector to load |
| fill_s_i | input | BV_LEN | Size vector to load |
| fill_x_i | input | BV_LEN | Mark vector to load |
| fill_cap_i | input | log2(BV_LEN)+1 | Capacity to load |
| victim_idx_o | output | log2(N_ENT) | Slot the next fill writes |

## Verification
The assertions assume that at most one of allocation request, mark request, fill and update is active in any cycle. They also assume that an update arrives only in the cycle right after an allocation hit, since the write-back targets the slot then held in `hit_idx_o`. The bench drives each operation alone for one cycle and then returns to idle. It issues updates only right after it has seen `alloc_hit_o` high. Slot contents are picked so that equal-size fits, wrong-owner slots and multiple fits each produce a result that can be told apart at the ports.

// File: rtl/alb_pkg.sv
package alb_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_ALLOC = 3'd1,
    OP_MARK  = 3'd2,
    OP_FILL  = 3'd3,
    OP_UPD   = 3'd4
  } alb_op_e;
endpackage

// File: rtl/alb_match.sv
// Parallel key compare over all slots with lowest-index pick.
module alb_match #(
  parameter int N_ENT   = 4,
  parameter int KEY_W   = 10,
  parameter int PID_W   = 4,
  parameter bit USE_PID = 1'b1,
  parameter bit GE_CMP  = 1'b1,
  localparam int IDX_W  = $clog2(N_ENT)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_ENT-1:0]       valid_i,
  input  logic [N_ENT*PID_W-1:0] pids_i,
  input  logic [N_ENT*KEY_W-1:0] keys_i,
  input  logic [PID_W-1:0]       pid_i,
  input  logic [KEY_W-1:0]       probe_i,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [N_ENT-1:0] hit_vec;
  logic [N_ENT-1:0] below;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    logic pid_ok, key_ok;
    if (USE_PID) begin : g_pid
      assign pid_ok = (pids_i[g*PID_W +: PID_W] == pid_i);
    end else begin : g_nopid
      assign pid_ok = 1'b1;
    end
    if (GE_CMP) begin : g_ge
      assign key_ok = (keys_i[g*KEY_W +: KEY_W] >= probe_i);
    end else begin : g_eq
      assign key_ok = (keys_i[g*KEY_W +: KEY_W] == probe_i);
    end
    assign hit_vec[g] = valid_i[g] & pid_ok & key_ok;
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_ENT; i++) below[i] = (IDX_W'(i) < idx_o);
  end

  a_r3_lowest_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (hit_vec[idx_o] && ((hit_vec & below) == '0)));

  a_r4_empty_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i == '0) |-> !hit_o);
endmodule

// File: rtl/alb_victim.sv
// Fill target: lowest empty slot, else round-robin eviction pointer.
module alb_victim #(
  parameter int N_ENT  = 4,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] valid_i,
  input  logic             fill_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] fifo_q;
  logic [IDX_W-1:0] first_free;
  logic             full;

  assign full = &valid_i;

  always_comb begin
    first_free = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!valid_i[i]) first_free = IDX_W'(i);
    end
  end

  assign victim_o = full ? fifo_q : first_free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_q <= '0;
    end else if (fill_i && full) begin
      fifo_q <= (fifo_q == IDX_W'(N_ENT - 1)) ? '0 : fifo_q + 1'b1;
    end
  end

  a_r9_fill_free_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !full) |-> !valid_i[victim_o]);

  a_r10_fifo_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && full && fifo_q != IDX_W'(N_ENT - 1)) |=> (fifo_q == $past(fifo_q) + 1'b1));
endmodule

// File: rtl/alloc_lookaside_buf.sv
module alloc_lookaside_buf
  import alb_pkg::*;
#(
  parameter int N_ENT   = 4,
  parameter int BV_LEN  = 512,
  parameter int PAGE_W  = 20,
  parameter int PID_W   = 4,
  parameter bit USE_PID = 1'b1,
  localparam int OFF_W  = $clog2(BV_LEN),
  localparam int SIZE_W = OFF_W + 1,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int PTR_W  = PAGE_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PID_W-1:0]  pid_i,
  input  logic              alloc_req_i,
  input  logic [SIZE_W-1:0] alloc_size_i,
  input  logic              mark_req_i,
  input  logic [PTR_W-1:0]  mark_ptr_i,
  output logic              alloc_hit_o,
  output logic              alloc_miss_o,
  output logic              mark_hit_o,
  output logic              mark_miss_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [OFF_W-1:0]  mark_off_o,
  output logic [BV_LEN-1:0] sel_a_o,
  output logic [BV_LEN-1:0] sel_s_o,
  output logic [BV_LEN-1:0] sel_x_o,
  output logic [SIZE_W-1:0] sel_cap_o,
  input  logic              upd_en_i,
  input  logic [BV_LEN-1:0] upd_a_i,
  input  logic [BV_LEN-1:0] upd_s_i,
  input  logic [SIZE_W-1:0] upd_cap_i,
  input  logic [OFF_W-1:0]  upd_off_i,
  output logic              ptr_vld_o,
  output logic [PTR_W-1:0]  obj_ptr_o,
  input  logic              fill_en_i,
  input  logic [PID_W-1:0]  fill_pid_i,
  input  logic [PAGE_W-1:0] fill_page_i,
  input  logic [BV_LEN-1:0] fill_a_i,
  input  logic [BV_LEN-1:0] fill_s_i,
  input  logic [BV_LEN-1:0] fill_x_i,
  input  logic [SIZE_W-1:0] fill_cap_i,
  output logic [IDX_W-1:0]  victim_idx_o
);
  logic [N_ENT-1:0]  valid_q;
  logic [PAGE_W-1:0] page_q [N_ENT];
  logic [PID_W-1:0]  pid_q  [N_ENT];
  logic [SIZE_W-1:0] cap_q  [N_ENT];
  logic [BV_LEN-1:0] a_q    [N_ENT];
  logic [BV_LEN-1:0] s_q    [N_ENT];
  logic [BV_LEN-1:0] x_q    [N_ENT];

  logic [N_ENT*PID_W-1:0]  pid_flat;
  logic [N_ENT*SIZE_W-1:0] cap_flat;
  logic [N_ENT*PAGE_W-1:0] page_flat;

  for (genvar g = 0; g < N_ENT; g++) begin : g_flat
    assign pid_flat[g*PID_W +: PID_W]    = pid_q[g];
    assign cap_flat[g*SIZE_W +: SIZE_W]  = cap_q[g];
    assign page_flat[g*PAGE_W +: PAGE_W] = page_q[g];
  end

  logic [PAGE_W-1:0] mk_page;
  logic [OFF_W-1:0]  mk_off;
  assign mk_page = mark_ptr_i[PTR_W-1:OFF_W];
  assign mk_off  = mark_ptr_i[OFF_W-1:0];

  logic             a_hit, m_hit;
  logic [IDX_W-1:0] a_idx, m_idx;

  alb_match #(.N_ENT(N_ENT), .KEY_W(SIZE_W), .PID_W(PID_W),
              .USE_PID(USE_PID), .GE_CMP(1'b1)) u_alloc_match (
    .clk_i, .rst_ni, .valid_i(valid_q), .pids_i(pid_flat), .keys_i(cap_flat),
    .pid_i, .probe_i(alloc_size_i), .hit_o(a_hit), .idx_o(a_idx));

  alb_match #(.N_ENT(N_ENT), .KEY_W(PAGE_W), .PID_W(PID_W),
              .USE_PID(USE_PID), .GE_CMP(1'b0)) u_mark_match (
    .clk_i, .rst_ni, .valid_i(valid_q), .pids_i(pid_flat), .keys_i(page_flat),
    .pid_i, .probe_i(mk_page), .hit_o(m_hit), .idx_o(m_idx));

  logic [IDX_W-1:0] victim;
  alb_victim #(.N_ENT(N_ENT)) u_victim (
    .clk_i, .rst_ni, .valid_i(valid_q), .fill_i(fill_en_i), .victim_o(victim));
  assign victim_idx_o = victim;

  alb_op_e op;
  always_comb begin
    if (fill_en_i)        op = OP_FILL;
    else if (alloc_req_i) op = OP_ALLOC;
    else if (mark_req_i)  op = OP_MARK;
    else if (upd_en_i)    op = OP_UPD;
    else                  op = OP_IDLE;
  end

  logic [IDX_W-1:0] idx_q;

  // slot storage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        page_q[i] <= '0;
        pid_q[i]  <= '0;
        cap_q[i]  <= '0;
        a_q[i]    <= '0;
        s_q[i]    <= '0;
        x_q[i]    <= '0;
      end
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        unique case (op)
          OP_FILL: if (victim == IDX_W'(i)) begin
            valid_q[i] <= 1'b1;
            page_q[i]  <= fill_page_i;
            pid_q[i]   <= fill_pid_i;
            cap_q[i]   <= fill_cap_i;
            a_q[i]     <= fill_a_i;
            s_q[i]     <= fill_s_i;
            x_q[i]     <= fill_x_i;
          end
          OP_UPD: if (idx_q == IDX_W'(i)) begin
            a_q[i]   <= upd_a_i;
            s_q[i]   <= upd_s_i;
            cap_q[i] <= upd_cap_i;
          end
          OP_MARK: if (m_hit && m_idx == IDX_W'(i)) x_q[i][mk_off] <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // lookup and pointer results
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_hit_o  <= 1'b0;
      alloc_miss_o <= 1'b0;
      mark_hit_o   <= 1'b0;
      mark_miss_o  <= 1'b0;
      idx_q        <= '0;
      mark_off_o   <= '0;
      ptr_vld_o    <= 1'b0;
      obj_ptr_o    <= '0;
    end else begin
      alloc_hit_o  <= (op == OP_ALLOC) &&  a_hit;
      alloc_miss_o <= (op == OP_ALLOC) && !a_hit;
      mark_hit_o   <= (op == OP_MARK)  &&  m_hit;
      mark_miss_o  <= (op == OP_MARK)  && !m_hit;
      ptr_vld_o    <= (op == OP_UPD);
      if (op == OP_ALLOC && a_hit) idx_q <= a_idx;
      if (op == OP_MARK && m_hit)  idx_q <= m_idx;
      if (op == OP_MARK)           mark_off_o <= mk_off;
      if (op == OP_UPD)            obj_ptr_o <= {page_q[idx_q], upd_off_i};
    end
  end

  assign hit_idx_o = idx_q;
  assign sel_a_o   = a_q[idx_q];
  assign sel_s_o   = s_q[idx_q];
  assign sel_x_o   = x_q[idx_q];
  assign sel_cap_o = cap_q[idx_q];

  // input contract: one operation per cycle
  a_r11_one_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({alloc_req_i, mark_req_i, fill_en_i, upd_en_i}));

  a_r2_alloc_answers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_req_i |=> (alloc_hit_o || alloc_miss_o));

  a_r11_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_req_i || mark_req_i) |=> !(alloc_hit_o || alloc_miss_o || mark_hit_o || mark_miss_o));

  a_r11_excl_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_hit_o && alloc_miss_o) && !(mark_hit_o && mark_miss_o));

  a_r5_mark_bit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_hit_o |-> sel_x_o[mark_off_o]);

  a_r2_fit_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_hit_o |-> (sel_cap_o >= $past(alloc_size_i)));

  a_r6_miss_keeps_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_req_i && !m_hit) |=> $stable(hit_idx_o));

  a_r8_ptr_follows_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> ptr_vld_o);
endmodule

// File: tb/alloc_lookaside_buf_tb_top.sv
module alloc_lookaside_buf_tb_top;
  localparam int CLK_P  = 10;
  localparam int N_ENT  = 4;
  localparam int BV_LEN = 64;
  localparam int PAGE_W = 8;
  localparam int PID_W  = 4;
  localparam int OFF_W  = 6;
  localparam int SIZE_W = 7;
  localparam int IDX_W  = 2;
  localparam int PTR_W  = PAGE_W + OFF_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [PID_W-1:0]  pid;
  logic              alloc_req, mark_req, upd_en, fill_en;
  logic [SIZE_W-1:0] alloc_size, upd_cap, fill_cap, sel_cap;
  logic [PTR_W-1:0]  mark_ptr, obj_ptr;
  logic              alloc_hit, alloc_miss, mark_hit, mark_miss, ptr_vld;
  logic [IDX_W-1:0]  hit_idx, victim_idx;
  logic [OFF_W-1:0]  mark_off, upd_off;
  logic [BV_LEN-1:0] sel_a, sel_s, sel_x, upd_a, upd_s, fill_a, fill_s, fill_x;
  logic [PID_W-1:0]  fill_pid;
  logic [PAGE_W-1:0] fill_page;

  alloc_lookaside_buf #(.N_ENT(N_ENT), .BV_LEN(BV_LEN), .PAGE_W(PAGE_W),
                        .PID_W(PID_W), .USE_PID(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pid_i(pid),
    .alloc_req_i(alloc_req), .alloc_size_i(alloc_size),
    .mark_req_i(mark_req), .mark_ptr_i(mark_ptr),
    .alloc_hit_o(alloc_hit), .alloc_miss_o(alloc_miss),
    .mark_hit_o(mark_hit), .mark_miss_o(mark_miss),
    .hit_idx_o(hit_idx), .mark_off_o(mark_off),
    .sel_a_o(sel_a), .sel_s_o(sel_s), .sel_x_o(sel_x), .sel_cap_o(sel_cap),
    .upd_en_i(upd_en), .upd_a_i(upd_a), .upd_s_i(upd_s), .upd_cap_i(upd_cap),
    .upd_off_i(upd_off), .ptr_vld_o(ptr_vld), .obj_ptr_o(obj_ptr),
    .fill_en_i(fill_en), .fill_pid_i(fill_pid), .fill_page_i(fill_page),
    .fill_a_i(fill_a), .fill_s_i(fill_s), .fill_x_i(fill_x), .fill_cap_i(fill_cap),
    .victim_idx_o(victim_idx));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [7:0] b);
    return {8{b}};
  endfunction

  task automatic idle();
    pid = '0; alloc_req = 0; alloc_size = '0; mark_req = 0; mark_ptr = '0;
    upd_en = 0; upd_a = '0; upd_s = '0; upd_cap = '0; upd_off = '0;
    fill_en = 0; fill_pid = '0; fill_page = '0; fill_a = '0; fill_s = '0;
    fill_x = '0; fill_cap = '0;
  endtask

  task automatic do_alloc(input logic [3:0] p, input logic [6:0] sz);
    pid = p; alloc_size = sz; alloc_req = 1;
    @(negedge clk);
    alloc_req = 0;
  endtask

  task automatic do_mark(input logic [3:0] p, input logic [7:0] pg, input logic [5:0] off);
    pid = p; mark_ptr = {pg, off}; mark_req = 1;
    @(negedge clk);
    mark_req = 0;
  endtask

  task automatic do_fill(input logic [3:0] p, input logic [7:0] pg, input logic [6:0] cap);
    fill_pid = p; fill_page = pg; fill_a = pat(pg); fill_s = ~pat(pg);
    fill_x = '0; fill_cap = cap; fill_en = 1;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic t_reset();
    chk("R1 alloc_hit", alloc_hit, 0);
    chk("R1 alloc_miss", alloc_miss, 0);
    chk("R1 mark_hit", mark_hit, 0);
    chk("R1 ptr_vld", ptr_vld, 0);
    chk("R1 victim", victim_idx, 0);
  endtask

  task automatic t_empty_miss();
    do_alloc(4'd1, 7'd1);
    chk("R4 miss on empty", alloc_miss, 1);
    chk("R4 no hit on empty", alloc_hit, 0);
  endtask

  task automatic t_fill_free();
    chk("R9 victim first", victim_idx, 0);
    do_fill(4'd1, 8'h10, 7'd4);
    chk("R9 victim second", victim_idx, 1);
    do_fill(4'd1, 8'h11, 7'd20);
    chk("R9 victim third", victim_idx, 2);
    do_fill(4'd2, 8'h12, 7'd64);
    chk("R9 victim fourth", victim_idx, 3);
    do_fill(4'd1, 8'h13, 7'd20);
    chk("R10 victim when full", victim_idx, 0);
  endtask

  task automatic t_alloc_lookup();
    do_alloc(4'd1, 7'd4);
    chk("R2 equal fits", alloc_hit, 1);
    chk("R3 idx equal", hit_idx, 0);
    chk("R3 sel_cap", sel_cap, 4);
    chk("R3 sel_a", sel_a, pat(8'h10));
    chk("R3 sel_s", sel_s, ~pat(8'h10));
    @(negedge clk);
    chk("R11 hit pulse ends", alloc_hit, 0);
    do_alloc(4'd1, 7'd5);
    chk("R3 lowest of two fits", hit_idx, 1);
    chk("R2 hit size5", alloc_hit, 1);
    do_alloc(4'd1, 7'd21);
    chk("R7 other pid ignored", alloc_miss, 1);
    chk("R11 no hit with miss", alloc_hit, 0);
    do_alloc(4'd2, 7'd64);
    chk("R7 own pid hits", alloc_hit, 1);
    chk("R7 idx pid2", hit_idx, 2);
    do_alloc(4'd2, 7'd65);
    chk("R2 one over capacity", alloc_miss, 1);
  endtask

  task automatic t_update();
    do_alloc(4'd1, 7'd10);
    chk("R8 precondition hit", alloc_hit, 1);
    chk("R8 precondition idx", hit_idx, 1);
    upd_a = pat(8'hEE); upd_s = '0; upd_cap = 7'd3; upd_off = 6'd7; upd_en = 1;
    @(negedge clk);
    upd_en = 0;
    chk("R8 ptr valid", ptr_vld, 1);
    chk("R8 obj ptr", obj_ptr, 64'h447);
    chk("R8 sel_a written", sel_a, pat(8'hEE));
    chk("R8 cap written", sel_cap, 3);
    @(negedge clk);
    chk("R11 ptr pulse ends", ptr_vld, 0);
    do_alloc(4'd1, 7'd10);
    chk("R8 updated cap skips slot", hit_idx, 3);
  endtask

  task automatic t_mark();
    do_mark(4'd1, 8'h13, 6'd5);
    chk("R5 mark hit", mark_hit, 1);
    chk("R5 mark idx", hit_idx, 3);
    chk("R5 offset out", mark_off, 5);
    chk("R5 x bit set", sel_x, 64'h20);
    do_mark(4'd2, 8'h13, 6'd9);
    chk("R7 mark other pid", mark_miss, 1);
    chk("R6 x unchanged pid", sel_x, 64'h20);
    do_mark(4'd1, 8'h55, 6'd9);
    chk("R6 mark page miss", mark_miss, 1);
    chk("R6 no mark hit", mark_hit, 0);
    chk("R6 idx kept", hit_idx, 3);
    chk("R6 x unchanged page", sel_x, 64'h20);
  endtask

  task automatic t_evict();
    do_fill(4'd1, 8'h20, 7'd30);
    chk("R10 pointer step", victim_idx, 1);
    do_alloc(4'd1, 7'd25);
    chk("R10 new page in slot0", hit_idx, 0);
    chk("R10 new contents", sel_a, pat(8'h20));
    do_fill(4'd3, 8'h21, 7'd8);
    chk("R10 pointer step2", victim_idx, 2);
    do_alloc(4'd3, 7'd8);
    chk("R10 slot1 replaced", hit_idx, 1);
    do_fill(4'd3, 8'h22, 7'd8);
    do_fill(4'd3, 8'h23, 7'd8);
    chk("R10 pointer wraps", victim_idx, 0);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty_miss();
    t_fill_free();
    t_alloc_lookup();
    t_update();
    t_mark();
    t_evict();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule